// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one timer channel bound to a single pin. A 16-bit data register serves three jobs, picked by a 4-bit mode field in a small control register. In capture modes it records the value of an external free-running timer when the pin shows a chosen edge, with optional prescaling of rising edges. In compare modes it is matched against that timer, and a match drives one of several pin or event actions. In PWM mode its low byte, together with two fraction bits from the control register, forms a 10-bit duty value. That duty value is compared against an external 8-bit timebase extended by two prescale bits.

Control is a five-state machine. ST_OFF, ST_CAPTURE, ST_COMPARE, ST_PWM and ST_RESERVED are loaded from the decoded mode field on every control write, and the state holds between writes. Any state can move to any other through a control write. Mode 0000 moves to ST_OFF, 01xx to ST_CAPTURE, 0010 and 10xx to ST_COMPARE, 11xx to ST_PWM, and 0001 and 0011 to ST_RESERVED. The pin output is registered in every mode. The interrupt flag is sticky. The special-event output is a one-cycle pulse.

Top module: `ccp_unit`

## Requirements
- R1: The control register keeps the mode field in bits 3:0 and the duty fraction in bits 5:4, and both read back as written. The 8-bit readback shows bits 7:6 as zero.
- R2: Reset and mode 0000 both drive pin_out low. While the channel sits in mode 0000, the capture edge prescaler and the latched PWM duty are cleared.
- R3: Mode 0101 captures on each rising pin edge and mode 0100 on each falling edge. The pin passes two synchronizer flops, so the third rising clock edge after a pin change loads tmr_val into the data register. Every capture sets irq_flag.
- R4: Modes 0110 and 0111 capture on every 4th and every 16th rising edge. The edges are counted from the point the channel left mode 0000 or reset.
- R5: In mode 0010, each clock edge at which tmr_val equals the data register toggles pin_out and sets irq_flag.
- R6: A control write of mode 1000 drives pin_out low, and a later match drives it high. A control write of mode 1001 drives pin_out high, and a later match drives it low. Both matches set irq_flag.
- R7: In mode 1010 a match only sets irq_flag. In mode 1011 a match also raises evt_pulse for exactly the following cycle. Neither mode changes pin_out.
- R8: Modes 0001 and 0011 do nothing. No capture happens, irq_flag is not set, and pin_out keeps its value.
- R9: irq_flag stays set until flag_clr is asserted. If a set and a clear fall in the same cycle, the set wins.
- R10: In modes 11xx the duty is {data[7:0], ctl[5:4]} and the timebase is {pwm_cnt, pwm_pre}. After each clock edge, pin_out is 1 exactly when the timebase presented at that edge was below the latched duty.
- R11: The latched duty loads from the programmed duty only at the clock edge where the timebase equals {pwm_prd, 2'b11}. Register writes made mid-period do not affect the current period.
- R12: The lo_wr and hi_wr strobes load data bits 7:0 and 15:8 at the next clock edge, and data_q shows the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data: 5:4 duty fraction, 3:0 mode |
| lo_wr | input | 1 | Data register low byte write strobe |
| lo_wdata | input | 8 | Data low byte |
| hi_wr | input | 1 | Data register high byte write strobe |
| hi_wdata | input | 8 | Data high byte |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_val | input | 16 | Free-running timer value |
| pwm_cnt | input | 8 | PWM timebase count |
| pwm_pre | input | 2 | PWM timebase prescale bits (low end of the 10-bit timebase) |
| pwm_prd | input | 8 | PWM period value |
| pin_in | input | 1 | Pin input (asynchronous) |
| pin_out | output | 1 | Pin output |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_pulse | output | 1 | One-cycle special-event trigger |
| ctl_rd | output | 8 | Control register readback |
| data_q | output | 16 | Data register |

## Verification
The hardest situation to reach is a prescaler that holds a partial count of edges when the channel is switched off. A missing clear is only visible as a capture that arrives too early, many edges later. The bench feeds five rising edges in the every-16th mode, passes through mode 0000, and returns. It then feeds fifteen pulses that must leave the data register alone, and a sixteenth that must load it. The double-buffered duty is the other hard case. The bench rewrites both duty parts mid-period for a sweep of duty values and two periods, and predicts every PWM cycle from a model that only updates at the period end.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CAPTURE,
        ST_COMPARE,
        ST_PWM,
        ST_RESERVED
    } ccp_state_e;

    typedef enum logic [1:0] {
        EDGE_FALL   = 2'b00,
        EDGE_RISE   = 2'b01,
        EDGE_RISE_A = 2'b10,
        EDGE_RISE_B = 2'b11
    } edge_sel_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TOGGLE,
        ACT_DRIVE_HI,
        ACT_DRIVE_LO,
        ACT_EVENT
    } cmp_act_e;

    localparam logic [3:0] MODE_OFF      = 4'b0000;
    localparam logic [3:0] MODE_CMP_TGL  = 4'b0010;
    localparam logic [3:0] MODE_CMP_HI   = 4'b1000;
    localparam logic [3:0] MODE_CMP_LO   = 4'b1001;
    localparam logic [3:0] MODE_CMP_FLAG = 4'b1010;
    localparam logic [3:0] MODE_CMP_EVT  = 4'b1011;

    function automatic ccp_state_e decode_mode(input logic [3:0] m);
        ccp_state_e s;
        if (m == MODE_OFF)
            s = ST_OFF;
        else if (m[3:2] == 2'b11)
            s = ST_PWM;
        else if (m[3:2] == 2'b10 || m == MODE_CMP_TGL)
            s = ST_COMPARE;
        else if (m[3:2] == 2'b01)
            s = ST_CAPTURE;
        else
            s = ST_RESERVED;
        return s;
    endfunction

endpackage

// File: rtl/ccp_edge_cap.sv
`timescale 1ns/1ps
module ccp_edge_cap
    import ccp_pkg::*;
#(
    parameter int SYNC_N  = 2,
    parameter int PRESC_A = 4,
    parameter int PRESC_B = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      en,
    input  edge_sel_e sel,
    input  logic      pin_in,
    output logic      hit
);
    localparam int PS_W = $clog2(PRESC_B);
    localparam logic [PS_W-1:0] LAST_A = PS_W'(PRESC_A - 1);
    localparam logic [PS_W-1:0] LAST_B = PS_W'(PRESC_B - 1);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic [PS_W-1:0]   ps_q;
    logic              pin_s;
    logic              rise;
    logic              fall;
    logic              edge_seen;
    logic [PS_W-1:0]   last;

    // synchronizer chain, one stage per flop
    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign pin_s = sync_q[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    always_comb begin
        unique case (sel)
            EDGE_FALL:   begin edge_seen = fall; last = '0;     end
            EDGE_RISE:   begin edge_seen = rise; last = '0;     end
            EDGE_RISE_A: begin edge_seen = rise; last = LAST_A; end
            EDGE_RISE_B: begin edge_seen = rise; last = LAST_B; end
            default:     begin edge_seen = 1'b0; last = '0;     end
        endcase
    end

    assign hit = en && edge_seen && (ps_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_q <= '0;
        else if (clr)
            ps_q <= '0;
        else if (en && edge_seen)
            ps_q <= (ps_q == last) ? '0 : ps_q + 1'b1;
    end

endmodule

// File: rtl/ccp_cmp_eval.sv
`timescale 1ns/1ps
module ccp_cmp_eval
    import ccp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             en,
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             hit,
    output cmp_act_e         act
);
    logic match;

    assign match = en && (tmr_val == cmp_val);
    assign hit   = match;

    always_comb begin
        act = ACT_NONE;
        if (match) begin
            unique case (mode)
                MODE_CMP_TGL:  act = ACT_TOGGLE;
                MODE_CMP_HI:   act = ACT_DRIVE_HI;
                MODE_CMP_LO:   act = ACT_DRIVE_LO;
                MODE_CMP_EVT:  act = ACT_EVENT;
                default:       act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ccp_pwm_gen.sv
`timescale 1ns/1ps
module ccp_pwm_gen #(
    parameter int PWM_W = 8,
    parameter int PRE_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic [PWM_W+PRE_W-1:0] duty_buf,
    input  logic [PWM_W-1:0]       cnt,
    input  logic [PRE_W-1:0]       pre,
    input  logic [PWM_W-1:0]       prd,
    output logic                   level
);
    localparam int DW = PWM_W + PRE_W;

    logic [DW-1:0] tb;
    logic [DW-1:0] duty_q;
    logic          prd_end;

    assign tb      = {cnt, pre};
    assign prd_end = (tb == {prd, {PRE_W{1'b1}}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            duty_q <= '0;
        else if (clr)
            duty_q <= '0;
        else if (en && prd_end)
            duty_q <= duty_buf;
    end

    assign level = (tb < duty_q);

endmodule

// File: rtl/ccp_unit.sv
`timescale 1ns/1ps
module ccp_unit
    import ccp_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int PWM_W   = 8,
    parameter int PRE_W   = 2,
    parameter int SYNC_N  = 2,
    parameter int PRESC_A = 4,
    parameter int PRESC_B = 16,
    parameter int RD_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [PRE_W+3:0]   ctl_wdata,
    input  logic               lo_wr,
    input  logic [TMR_W/2-1:0] lo_wdata,
    input  logic               hi_wr,
    input  logic [TMR_W/2-1:0] hi_wdata,
    input  logic               flag_clr,
    input  logic [TMR_W-1:0]   tmr_val,
    input  logic [PWM_W-1:0]   pwm_cnt,
    input  logic [PRE_W-1:0]   pwm_pre,
    input  logic [PWM_W-1:0]   pwm_prd,
    input  logic               pin_in,
    output logic               pin_out,
    output logic               irq_flag,
    output logic               evt_pulse,
    output logic [RD_W-1:0]    ctl_rd,
    output logic [TMR_W-1:0]   data_q
);
    localparam int HALF  = TMR_W / 2;
    localparam int CTL_W = PRE_W + 4;
    localparam int DW    = PWM_W + PRE_W;

    ccp_state_e       st_q;
    ccp_state_e       st_d;
    logic [CTL_W-1:0] ctl_q;
    logic [TMR_W-1:0] data_r;
    logic             flag_q;
    logic             evt_q;
    logic             pin_q;

    logic             cap_en;
    logic             cmp_en;
    logic             pwm_en;
    logic             off_clr;
    logic             cap_hit;
    logic             cmp_hit;
    cmp_act_e         cmp_act;
    logic             pwm_level;
    logic [DW-1:0]    duty_buf;
    logic             enter_lo;
    logic             enter_hi;

    // next-state: every control write reloads the state from the mode field
    always_comb begin
        st_d = st_q;
        if (ctl_wr)
            st_d = decode_mode(ctl_wdata[3:0]);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // state-driven enables
    always_comb begin
        cap_en  = 1'b0;
        cmp_en  = 1'b0;
        pwm_en  = 1'b0;
        off_clr = 1'b0;
        unique case (st_q)
            ST_OFF:      off_clr = 1'b1;
            ST_CAPTURE:  cap_en  = 1'b1;
            ST_COMPARE:  cmp_en  = 1'b1;
            ST_PWM:      pwm_en  = 1'b1;
            ST_RESERVED: ;
            default:     ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    assign ctl_rd = {{(RD_W-CTL_W){1'b0}}, ctl_q};

    ccp_edge_cap #(
        .SYNC_N  (SYNC_N),
        .PRESC_A (PRESC_A),
        .PRESC_B (PRESC_B)
    ) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (off_clr),
        .en     (cap_en),
        .sel    (edge_sel_e'(ctl_q[1:0])),
        .pin_in (pin_in),
        .hit    (cap_hit)
    );

    ccp_cmp_eval #(
        .TMR_W (TMR_W)
    ) u_cmp (
        .en      (cmp_en),
        .mode    (ctl_q[3:0]),
        .tmr_val (tmr_val),
        .cmp_val (data_r),
        .hit     (cmp_hit),
        .act     (cmp_act)
    );

    assign duty_buf = {data_r[PWM_W-1:0], ctl_q[CTL_W-1:4]};

    ccp_pwm_gen #(
        .PWM_W (PWM_W),
        .PRE_W (PRE_W)
    ) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (off_clr),
        .en       (pwm_en),
        .duty_buf (duty_buf),
        .cnt      (pwm_cnt),
        .pre      (pwm_pre),
        .prd      (pwm_prd),
        .level    (pwm_level)
    );

    // data register: capture loads the timer, otherwise byte writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_r <= '0;
        end else if (cap_hit) begin
            data_r <= tmr_val;
        end else begin
            if (lo_wr) data_r[HALF-1:0]     <= lo_wdata;
            if (hi_wr) data_r[TMR_W-1:HALF] <= hi_wdata;
        end
    end

    assign data_q = data_r;

    // sticky flag, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (cap_hit || cmp_hit) flag_q <= 1'b1;
        else if (flag_clr)          flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= (cmp_act == ACT_EVENT);
    end

    assign enter_lo = ctl_wr && (ctl_wdata[3:0] == MODE_CMP_HI);
    assign enter_hi = ctl_wr && (ctl_wdata[3:0] == MODE_CMP_LO);

    // output process: pin register by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (enter_lo) begin
            pin_q <= 1'b0;
        end else if (enter_hi) begin
            pin_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_OFF:      pin_q <= 1'b0;
                ST_PWM:      pin_q <= pwm_level;
                ST_COMPARE: begin
                    unique case (cmp_act)
                        ACT_TOGGLE:   pin_q <= ~pin_q;
                        ACT_DRIVE_HI: pin_q <= 1'b1;
                        ACT_DRIVE_LO: pin_q <= 1'b0;
                        default:      pin_q <= pin_q;
                    endcase
                end
                ST_CAPTURE:  pin_q <= pin_q;
                ST_RESERVED: pin_q <= pin_q;
                default:     pin_q <= pin_q;
            endcase
        end
    end

    assign pin_out   = pin_q;
    assign irq_flag  = flag_q;
    assign evt_pulse = evt_q;

endmodule

// File: rtl/ccp_unit_chk.sv
`timescale 1ns/1ps
module ccp_unit_chk #(
    parameter int TMR_W = 16,
    parameter int RD_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             lo_wr,
    input logic             hi_wr,
    input logic             flag_clr,
    input logic [TMR_W-1:0] tmr_val,
    input logic [RD_W-1:0]  ctl_rd,
    input logic [TMR_W-1:0] data_q,
    input logic             pin_out,
    input logic             irq_flag,
    input logic             evt_pulse
);
    logic [3:0] m;
    logic       is_cap;
    logic       is_cmp;
    logic       is_rsv;

    assign m      = ctl_rd[3:0];
    assign is_cap = (m[3:2] == 2'b01);
    assign is_cmp = (m[3:2] == 2'b10) || (m == 4'b0010);
    assign is_rsv = (m == 4'b0001) || (m == 4'b0011);

    // R2
    off_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(m == 4'b0000 && !ctl_wr) |-> !pin_out);

    // R8
    rsv_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_rsv && !ctl_wr) |-> $stable(pin_out));

    // R7
    evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(m == 4'b1011 && tmr_val == data_q));

    // R9
    flag_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(flag_clr));

    // R3
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(is_cap || is_cmp));

    // R3
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_cap && !lo_wr && !hi_wr) && !$stable(data_q)) |-> (data_q == $past(tmr_val)));

endmodule

bind ccp_unit ccp_unit_chk #(.TMR_W(TMR_W), .RD_W(RD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .lo_wr     (lo_wr),
    .hi_wr     (hi_wr),
    .flag_clr  (flag_clr),
    .tmr_val   (tmr_val),
    .ctl_rd    (ctl_rd),
    .data_q    (data_q),
    .pin_out   (pin_out),
    .irq_flag  (irq_flag),
    .evt_pulse (evt_pulse)
);

// File: tb/tb_ccp_unit.sv
`timescale 1ns/1ps
module tb_ccp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_wr;
    logic [5:0]  ctl_wdata;
    logic        lo_wr;
    logic [7:0]  lo_wdata;
    logic        hi_wr;
    logic [7:0]  hi_wdata;
    logic        flag_clr;
    logic [15:0] tmr_val;
    logic [7:0]  pwm_cnt;
    logic [1:0]  pwm_pre;
    logic [7:0]  pwm_prd;
    logic        pin_in;
    logic        pin_out;
    logic        irq_flag;
    logic        evt_pulse;
    logic [7:0]  ctl_rd;
    logic [15:0] data_q;

    int errs   = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ccp_unit dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .flag_clr(flag_clr), .tmr_val(tmr_val), .pwm_cnt(pwm_cnt),
        .pwm_pre(pwm_pre), .pwm_prd(pwm_prd), .pin_in(pin_in),
        .pin_out(pin_out), .irq_flag(irq_flag), .evt_pulse(evt_pulse),
        .ctl_rd(ctl_rd), .data_q(data_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [15:0] v);
        lo_wr = 1'b1; lo_wdata = v[7:0];
        hi_wr = 1'b1; hi_wdata = v[15:8];
        tick();
        lo_wr = 1'b0; hi_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic pulse();
        pin_in = 1'b1; tick(4);
        pin_in = 1'b0; tick(4);
    endtask

    task automatic set_tb(input int t);
        pwm_cnt = 8'(t >> 2);
        pwm_pre = 2'(t & 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] last;
        logic        exp_pin;
        ctl_wr = 0; ctl_wdata = 0; lo_wr = 0; lo_wdata = 0; hi_wr = 0; hi_wdata = 0;
        flag_clr = 0; tmr_val = 0; pwm_cnt = 0; pwm_pre = 0; pwm_prd = 0; pin_in = 0;
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick();

        // reset state (R2)
        check("R2 reset pin", 32'(pin_out), 0);
        check("R9 reset flag", 32'(irq_flag), 0);
        check("R7 reset evt", 32'(evt_pulse), 0);
        check("R12 reset data", 32'(data_q), 0);
        check("R1 reset ctl", 32'(ctl_rd), 0);

        // R1 control readback
        wr_ctl(6'h3F);
        check("R1 readback all ones", 32'(ctl_rd), 32'h3F);
        wr_ctl(6'h25);
        check("R1 readback mixed", 32'(ctl_rd), 32'h25);
        wr_ctl(6'h00);
        tick();

        // R12 byte writes
        lo_wr = 1; lo_wdata = 8'hCD; tick(); lo_wr = 0;
        check("R12 low byte", 32'(data_q), 32'h00CD);
        hi_wr = 1; hi_wdata = 8'hAB; tick(); hi_wr = 0;
        check("R12 high byte", 32'(data_q), 32'hABCD);

        // R3 latency: third clock edge after the pin change loads the timer
        wr_data(16'h1111);
        wr_ctl(6'h05);
        tmr_val = 16'h5A5A;
        pin_in = 1'b1;
        tick(2);
        check("R3 not yet captured", 32'(data_q), 32'h1111);
        tick();
        check("R3 captured on third edge", 32'(data_q), 32'h5A5A);
        check("R3 capture sets flag", 32'(irq_flag), 1);
        tick(3);
        pin_in = 1'b0; tick(4);
        clr_flag();

        // R3 / R4 capture sweep over all four capture modes
        for (int m = 4; m < 8; m++) begin
            int n;
            n = (m == 6) ? 4 : (m == 7) ? 16 : 1;
            wr_ctl(6'h00);
            tick();
            wr_data(16'h0000);
            wr_ctl(6'(m));
            clr_flag();
            last = 16'h0000;
            for (int p = 1; p <= 20; p++) begin
                bit cap;
                tmr_val = 16'((m << 12) + p * 17);
                pulse();
                cap = ((p % n) == 0);
                if (cap) last = tmr_val;
                check(m < 6 ? "R3 capture value" : "R4 prescaled capture value", 32'(data_q), 32'(last));
                check(m < 6 ? "R3 capture flag" : "R4 prescaled capture flag", 32'(irq_flag), 32'(cap));
                clr_flag();
            end
        end

        // R2 / R4 prescaler cleared by mode 0000
        wr_ctl(6'h07);
        tmr_val = 16'h0F0F;
        for (int p = 0; p < 5; p++) pulse();
        wr_ctl(6'h00);
        tick();
        wr_data(16'hBEEF);
        wr_ctl(6'h07);
        clr_flag();
        for (int p = 1; p <= 15; p++) begin
            tmr_val = 16'(16'h2000 + p);
            pulse();
        end
        check("R2 R4 no early capture after off", 32'(data_q), 32'hBEEF);
        tmr_val = 16'h3333;
        pulse();
        check("R4 capture on 16th edge after off", 32'(data_q), 32'h3333);

        // R5 toggle compare, with R9 set-beats-clear
        wr_ctl(6'h00);
        tick();
        wr_data(16'h1234);
        wr_ctl(6'h02);
        clr_flag();
        exp_pin = 1'b0;
        for (int k = 0; k < 12; k++) begin
            bit hitk;
            hitk = (k % 3) == 0;
            tmr_val = hitk ? 16'h1234 : 16'(16'h1234 + k * 3);
            flag_clr = 1'b1;
            tick();
            if (hitk) exp_pin = ~exp_pin;
            check("R5 toggle pin", 32'(pin_out), 32'(exp_pin));
            check("R9 flag set wins over clear", 32'(irq_flag), 32'(hitk));
        end
        flag_clr = 1'b0;
        tmr_val = 16'h0000;

        // R9 sticky flag
        tmr_val = 16'h1234; tick();
        tmr_val = 16'h0000; tick(3);
        check("R9 flag stays set", 32'(irq_flag), 1);
        clr_flag();
        check("R9 flag cleared", 32'(irq_flag), 0);

        // R6 forced-level compare modes over several compare values
        for (int v = 8; v <= 9; v++) begin
            for (int j = 0; j < 4; j++) begin
                logic [15:0] dv;
                dv = (j == 0) ? 16'h0000 : (j == 1) ? 16'h00FF : (j == 2) ? 16'hFFFF : 16'h8001;
                tmr_val = dv + 16'd1;
                wr_data(dv);
                clr_flag();
                wr_ctl(6'(v));
                check("R6 entry level", 32'(pin_out), 32'(v == 9));
                tick(2);
                check("R6 no match keeps level", 32'(pin_out), 32'(v == 9));
                check("R6 no match no flag", 32'(irq_flag), 0);
                tmr_val = dv; tick();
                tmr_val = dv + 16'd1;
                check("R6 match forces level", 32'(pin_out), 32'(v == 8));
                check("R6 match sets flag", 32'(irq_flag), 1);
                check("R6 no event", 32'(evt_pulse), 0);
            end
        end

        // R7 flag-only and event modes; pin preset high
        wr_data(16'h4321);
        tmr_val = 16'h0000;
        wr_ctl(6'h09);
        wr_ctl(6'h0A);
        clr_flag();
        tmr_val = 16'h4321; tick(); tmr_val = 16'h0000;
        check("R7 flag-only sets flag", 32'(irq_flag), 1);
        check("R7 flag-only keeps pin", 32'(pin_out), 1);
        check("R7 flag-only no event", 32'(evt_pulse), 0);
        wr_ctl(6'h0B);
        clr_flag();
        tmr_val = 16'h4321; tick(); tmr_val = 16'h0000;
        check("R7 event pulse high", 32'(evt_pulse), 1);
        check("R7 event sets flag", 32'(irq_flag), 1);
        check("R7 event keeps pin", 32'(pin_out), 1);
        tick();
        check("R7 event pulse one cycle", 32'(evt_pulse), 0);

        // R8 reserved codes
        for (int r = 0; r < 2; r++) begin
            wr_ctl(r == 0 ? 6'h01 : 6'h03);
            clr_flag();
            tmr_val = 16'h4321; tick(2); tmr_val = 16'h0000;
            pulse();
            check("R8 reserved keeps pin", 32'(pin_out), 1);
            check("R8 reserved no flag", 32'(irq_flag), 0);
            check("R8 reserved no capture", 32'(data_q), 32'h4321);
        end

        // R10 / R11 PWM sweep over duty values and two periods
        for (int pi = 0; pi < 2; pi++) begin
            int per;
            int prd;
            prd = (pi == 0) ? 2 : 4;
            per = (prd + 1) * 4;
            pwm_prd = 8'(prd);
            set_tb(0);
            wr_ctl(6'h00);
            tick();
            wr_data(16'h0000);
            wr_ctl(6'h0C);
            begin
                int dact;
                int duty_m;
                dact = 0;
                duty_m = 0;
                for (int j = 0; j < 8; j++) begin
                    int d;
                    d = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 2 : (j == 3) ? 7 :
                        (j == 4) ? 10 : (j == 5) ? 19 : (j == 6) ? 20 : 31;
                    for (int i = 0; i < 3 * per; i++) begin
                        int t;
                        int nd;
                        t = i % per;
                        nd = duty_m;
                        set_tb(t);
                        if (i < per && t == 1) begin
                            lo_wr = 1'b1; lo_wdata = 8'(d >> 2);
                            nd = ((d >> 2) << 2) | (duty_m & 3);
                        end
                        if (i < per && t == 2) begin
                            ctl_wr = 1'b1; ctl_wdata = 6'(8'h0C | ((d & 3) << 4));
                            nd = (duty_m & ~3) | (d & 3);
                        end
                        tick();
                        lo_wr = 1'b0; ctl_wr = 1'b0;
                        check(i < per ? "R11 old duty holds this period" : "R10 PWM level",
                              32'(pin_out), 32'(t < dact));
                        if (t == per - 1) dact = duty_m;
                        duty_m = nd;
                    end
                end
            end
        end

        // R2 mode 0000 from PWM high drives pin low
        wr_ctl(6'h00);
        tick();
        check("R2 off drives pin low", 32'(pin_out), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule